// File: doc/BRIEF.md
# ADC Conversion Command Queue Sequencer

This block walks a table of conversion commands and hands one command at a time to an external analog converter. Each command word holds a channel number and a pause bit. Two queues share the table and the converter. Queue 1 always starts at entry 0. Queue 2 starts at a programmable begin pointer. Each queue is started by its own trigger input.

A queue runs until it meets an end condition. The end conditions are: the end-of-queue channel code, the end of the table, and, for queue 1, the start of queue 2. A pause bit stops the queue after the command's conversion, and the next trigger resumes it. Completion, pause and trigger-overrun flags are kept for each queue and are cleared by writing a one. Interrupt strobes can be enabled separately for each queue's completion and pause events.

A single engine serves both queues, so at most one queue is active at any time. A paused queue does not hold the engine.

Top module: `adc_cmd_sequencer`

## Requirements
- R1: A command whose channel field (bits 5:0) equals 63 is an end-of-queue code. Reading it performs no conversion, sets the queue's completion flag and returns the queue to idle.
- R2: A command with the pause bit (bit 6) set is converted, then the queue's pause flag is set and its status becomes paused. The next trigger resumes at the following entry.
- R3: If the command after a paused command is an end condition, the pause and completion flags are both set and the status becomes idle, not paused.
- R4: A command that holds both the pause bit and channel 63 performs no conversion and completes the queue. Its pause flag stays clear.
- R5: Queue 1 ends when it reaches the entry selected by the queue 2 begin pointer. With that pointer at 0, a queue 1 trigger completes with no conversion.
- R6: Entry 63 is the last entry. A valid command there is converted, and the queue then completes and goes idle.
- R7: With the queue 2 begin pointer at 64..127, a queue 2 trigger completes at once with no conversion.
- R8: End conditions detected together produce a single completion, with one completion flag set and at most one completion strobe.
- R9: When cont_mode is 0, a trigger to an idle queue whose completion flag is still set is ignored. When cont_mode is 1, such a trigger restarts the queue at its first command. Either way, a restart begins at entry 0 for queue 1 and at the begin pointer for queue 2.
- R10: conv_req with conv_chan is held until conv_done. conv_result is then stored in the result array at the index of the command, and res_data shows entry res_addr combinationally.
- R11: A trigger that arrives while the engine is busy is ignored and sets that queue's overrun flag. When both triggers are accepted in the same cycle, queue 1 wins and queue 2 records an overrun.
- R12: Flags use the layout bit0 q1 complete, bit1 q1 pause, bit2 q1 overrun, bit3 q2 complete, bit4 q2 pause, bit5 q2 overrun. Each flag stays set until a one is written to the same bit of flag_clr. irq uses the layout bit0 q1 complete, bit1 q1 pause, bit2 q2 complete, bit3 q2 pause, and pulses for one cycle on each such event when the matching irq_en bit is set.
- R13: Status encoding is 00 idle, 01 active, 10 paused. Queue 2 starts at the begin pointer, and the two queues are never active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| cmd_we | input | 1 | command table write enable |
| cmd_addr | input | 6 | command table write index |
| cmd_data | input | 7 | command word: bit 6 pause, bits 5:0 channel |
| q2_begin | input | 7 | queue 2 begin pointer |
| trig1 | input | 1 | queue 1 trigger |
| trig2 | input | 1 | queue 2 trigger |
| cont_mode | input | 1 | allow restart while completion flag set |
| irq_en | input | 4 | strobe enables |
| flag_clr | input | 6 | write-one-to-clear for flags |
| conv_req | output | 1 | conversion request |
| conv_chan | output | 6 | channel to convert |
| conv_done | input | 1 | converter finished |
| conv_result | input | 10 | conversion result |
| res_addr | input | 6 | result array read index |
| res_data | output | 10 | result array read data |
| q1_status | output | 2 | queue 1 status |
| q2_status | output | 2 | queue 2 status |
| flags | output | 6 | sticky flags |
| irq | output | 4 | event strobes |

## Verification
The bench builds the block with its default widths: a 6-bit channel field, a 64-entry table and 10-bit results. With a full 64-entry table, the bench can exercise the last-entry completion, a queue 1 run that stops only at the table end, and queue 2 begin pointers beyond the table. The converter model answers after a few cycles and returns a value derived from the channel number. This lets each stored result be traced back to its table index and lets the bench count exactly which conversions took place.

// File: rtl/adc_cmd_sequencer.sv
module adc_cmd_sequencer #(
  parameter int CHW  = 6,
  parameter int RESW = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_we,
  input  logic [CHW-1:0]  cmd_addr,
  input  logic [CHW:0]    cmd_data,
  input  logic [CHW:0]    q2_begin,
  input  logic            trig1,
  input  logic            trig2,
  input  logic            cont_mode,
  input  logic [3:0]      irq_en,
  input  logic [5:0]      flag_clr,
  output logic            conv_req,
  output logic [CHW-1:0]  conv_chan,
  input  logic            conv_done,
  input  logic [RESW-1:0] conv_result,
  input  logic [CHW-1:0]  res_addr,
  output logic [RESW-1:0] res_data,
  output logic [1:0]      q1_status,
  output logic [1:0]      q2_status,
  output logic [5:0]      flags,
  output logic [3:0]      irq
);
  localparam int N = 1 << CHW;

  typedef enum logic [1:0] {E_IDLE, E_FETCH, E_WAIT} eng_t;

  logic [CHW:0]    cmd_mem [N];
  logic [RESW-1:0] res_mem [N];
  eng_t            st;
  logic            cur;
  logic [CHW:0]    ptr;
  logic [CHW:0]    pptr [2];
  logic [1:0]      paused;

  function automatic logic at_end(input logic q, input logic [CHW:0] p);
    at_end = p[CHW] || (!q && p == q2_begin) || (cmd_mem[p[CHW-1:0]][CHW-1:0] == '1);
  endfunction

  wire [CHW:0] nxt   = ptr + 1'b1;
  wire [CHW:0] cmd   = cmd_mem[ptr[CHW-1:0]];
  wire         busy  = st != E_IDLE;
  wire         ok1   = paused[0] | ~flags[0] | cont_mode;
  wire         ok2   = paused[1] | ~flags[3] | cont_mode;
  wire         acc1  = trig1 & ~busy & ok1;
  wire         acc2  = trig2 & ~busy & ok2 & ~acc1;
  wire         fend  = (st == E_FETCH) && at_end(cur, ptr);
  wire         done  = (st == E_WAIT) && conv_done;
  wire         pev   = done & cmd[CHW];
  wire         stop  = pev & at_end(cur, nxt);
  wire         cev   = fend | stop;

  wire [5:0] fset = {trig2 & (busy | acc1), pev & cur, cev & cur,
                     trig1 & busy, pev & ~cur, cev & ~cur};

  assign conv_req  = st == E_WAIT;
  assign conv_chan = cmd[CHW-1:0];
  assign res_data  = res_mem[res_addr];
  assign q1_status = (busy & ~cur) ? 2'b01 : paused[0] ? 2'b10 : 2'b00;
  assign q2_status = (busy &  cur) ? 2'b01 : paused[1] ? 2'b10 : 2'b00;

  always_ff @(posedge clk) begin
    if (cmd_we) cmd_mem[cmd_addr] <= cmd_data;
    if (done) res_mem[ptr[CHW-1:0]] <= conv_result;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      irq   <= '0;
    end else begin
      flags <= (flags & ~flag_clr) | fset;
      irq   <= {fset[4], fset[3], fset[1], fset[0]} & irq_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= E_IDLE;
      cur     <= 1'b0;
      ptr     <= '0;
      pptr[0] <= '0;
      pptr[1] <= '0;
      paused  <= '0;
    end else begin
      case (st)
        E_IDLE:
          if (acc1 | acc2) begin
            cur         <= acc2;
            ptr         <= paused[acc2] ? pptr[acc2] : (acc2 ? q2_begin : '0);
            paused[acc2] <= 1'b0;
            st          <= E_FETCH;
          end
        E_FETCH:
          st <= fend ? E_IDLE : E_WAIT;
        E_WAIT:
          if (conv_done) begin
            if (cmd[CHW]) begin
              st <= E_IDLE;
              if (!stop) begin
                paused[cur] <= 1'b1;
                pptr[cur]   <= nxt;
              end
            end else begin
              ptr <= nxt;
              st  <= E_FETCH;
            end
          end
        default: st <= E_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_cmd_sequencer_chk.sv
module adc_cmd_sequencer_chk #(
  parameter int CHW = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic           conv_req,
  input logic           conv_done,
  input logic [CHW-1:0] conv_chan,
  input logic [1:0]     q1_status,
  input logic [1:0]     q2_status,
  input logic [5:0]     flags,
  input logic [3:0]     irq
);
  // R10
  req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req && !conv_done |=> conv_req);
  // R1
  no_eoq_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_req) |-> conv_chan != '1);
  // R13
  one_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(q1_status == 2'b01 && q2_status == 2'b01));
  // R13
  status_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q1_status != 2'b11 && q2_status != 2'b11);
  // R3
  q1_done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[0]) |-> q1_status == 2'b00);
  // R3
  q2_done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[3]) |-> q2_status == 2'b00);
  // R12
  irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq[0] |-> flags[0]) and (irq[1] |-> flags[1]) and
    (irq[2] |-> flags[3]) and (irq[3] |-> flags[4]));
endmodule

bind adc_cmd_sequencer adc_cmd_sequencer_chk #(.CHW(CHW)) chk_i (
  .clk(clk), .rst_n(rst_n), .conv_req(conv_req), .conv_done(conv_done),
  .conv_chan(conv_chan), .q1_status(q1_status), .q2_status(q2_status),
  .flags(flags), .irq(irq));

// File: tb/adc_cmd_sequencer_test.sv
module adc_cmd_sequencer_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_we = 0; logic [5:0] cmd_addr = 0; logic [6:0] cmd_data = 0;
  logic [6:0] q2_begin = 0;
  logic trig1 = 0, trig2 = 0, cont_mode = 0;
  logic [3:0] irq_en = 0; logic [5:0] flag_clr = 0;
  logic conv_req; logic [5:0] conv_chan;
  logic conv_done = 0; logic [9:0] conv_result = 0;
  logic [5:0] res_addr = 0; logic [9:0] res_data;
  logic [1:0] q1_status, q2_status;
  logic [5:0] flags; logic [3:0] irq;

  int errors = 0, checks = 0, conv_cnt = 0;
  int irq_cnt [4];

  always #10 clk = ~clk;

  adc_cmd_sequencer uut (.*);

  initial begin
    for (int i = 0; i < 4; i++) irq_cnt[i] = 0;
    forever begin
      @(negedge clk);
      for (int i = 0; i < 4; i++) if (irq[i]) irq_cnt[i]++;
    end
  end

  initial forever begin
    @(negedge clk);
    if (conv_req && !conv_done) begin
      repeat (2) @(negedge clk);
      conv_result = {conv_chan, 4'hA};
      conv_done = 1'b1;
      conv_cnt++;
      @(negedge clk);
      conv_done = 1'b0;
    end
  end

  initial begin
    #3_000_000;
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; cont_mode = 0; irq_en = 0;
    repeat (2) @(negedge clk); rst_n = 1; @(negedge clk);
  endtask

  task automatic wr(input int a, input bit p, input int ch);
    @(negedge clk); cmd_we = 1; cmd_addr = 6'(a); cmd_data = {p, 6'(ch)};
    @(negedge clk); cmd_we = 0;
  endtask

  task automatic fill();
    for (int a = 0; a < 64; a++) wr(a, 1'b0, a % 32);
  endtask

  function automatic logic [1:0] stat(input bit q);
    return q ? q2_status : q1_status;
  endfunction

  task automatic run(input bit q);
    @(negedge clk); if (q) trig2 = 1; else trig1 = 1;
    @(negedge clk); trig1 = 0; trig2 = 0;
    for (int g = 0; g < 2000 && stat(q) == 2'b01; g++) @(negedge clk);
  endtask

  task automatic clr(input logic [5:0] m);
    @(negedge clk); flag_clr = m; @(negedge clk); flag_clr = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk(q1_status == 0 && q2_status == 0, "R13 reset status", q1_status, 0);
    chk(flags == 0 && irq == 0 && !conv_req, "R12 reset flags", flags, 0);
  endtask

  task automatic t_q1_bound();
    int c0;
    fill(); q2_begin = 8; c0 = conv_cnt;
    run(0);
    chk(conv_cnt - c0 == 8, "R5 q1 stops at begin pointer", conv_cnt - c0, 8);
    chk(flags == 6'b000001 && q1_status == 0, "R5 q1 completion", flags, 1);
    res_addr = 3; #1;
    chk(res_data == {6'd3, 4'hA}, "R10 result index", res_data, {6'd3, 4'hA});
  endtask

  task automatic t_q2_last();
    int c0;
    q2_begin = 60; c0 = conv_cnt;
    run(1);
    chk(conv_cnt - c0 == 4, "R6 q2 converts 60..63", conv_cnt - c0, 4);
    chk(flags[3] && q2_status == 0, "R6 complete after last entry", flags, 8);
    res_addr = 63; #1;
    chk(res_data == {6'd31, 4'hA}, "R6 entry 63 result", res_data, {6'd31, 4'hA});
  endtask

  task automatic t_eoq();
    int c0;
    do_reset(); fill(); q2_begin = 100; wr(2, 1'b0, 63); c0 = conv_cnt;
    run(0);
    chk(conv_cnt - c0 == 2, "R1 eoq code stops before entry 2", conv_cnt - c0, 2);
    chk(flags[0] && q1_status == 0, "R1 completion idle", flags, 1);
  endtask

  task automatic t_pause();
    int c0;
    do_reset(); fill(); q2_begin = 100;
    wr(1, 1'b1, 1); wr(3, 1'b1, 3); wr(4, 1'b0, 63); c0 = conv_cnt;
    run(0);
    chk(conv_cnt - c0 == 2 && q1_status == 2'b10, "R2 paused after entry 1", q1_status, 2);
    chk(flags == 6'b000010, "R2 pause flag only", flags, 2);
    clr(6'b000010); c0 = conv_cnt;
    run(0);
    chk(conv_cnt - c0 == 2, "R2 resumes at entry 2", conv_cnt - c0, 2);
    chk(flags == 6'b000011 && q1_status == 0, "R3 pause then eoq idle", flags, 3);
  endtask

  task automatic t_pause_eoq_same();
    int c0;
    do_reset(); fill(); q2_begin = 100; wr(0, 1'b1, 63); c0 = conv_cnt;
    run(0);
    chk(conv_cnt == c0, "R4 no conversion", conv_cnt - c0, 0);
    chk(flags == 6'b000001 && q1_status == 0, "R4 end wins over pause", flags, 1);
  endtask

  task automatic t_multi_end();
    int c0, i0;
    do_reset(); fill(); q2_begin = 0; wr(0, 1'b0, 63); irq_en = 4'b1111;
    c0 = conv_cnt; i0 = irq_cnt[0];
    run(0); repeat (2) @(negedge clk);
    chk(conv_cnt == c0 && flags == 6'b000001, "R5 begin pointer 0 no conversion", flags, 1);
    chk(irq_cnt[0] - i0 == 1, "R8 single completion strobe", irq_cnt[0] - i0, 1);
  endtask

  task automatic t_q2_beyond();
    int c0;
    do_reset(); fill(); q2_begin = 64; c0 = conv_cnt;
    run(1);
    chk(conv_cnt == c0 && flags == 6'b001000 && q2_status == 0, "R7 q2 beyond table", flags, 8);
  endtask

  task automatic t_modes();
    int c0;
    do_reset(); q2_begin = 2; run(0);
    c0 = conv_cnt;
    run(0);
    chk(conv_cnt == c0 && q1_status == 0, "R9 single mode ignores trigger", conv_cnt - c0, 0);
    clr(6'b000001); c0 = conv_cnt;
    run(0);
    chk(conv_cnt - c0 == 2 && flags[0], "R9 restart after clear", conv_cnt - c0, 2);
    cont_mode = 1; c0 = conv_cnt;
    run(0);
    chk(conv_cnt - c0 == 2, "R9 continuous restart", conv_cnt - c0, 2);
  endtask

  task automatic t_overrun();
    int c0;
    do_reset(); q2_begin = 100; c0 = conv_cnt;
    @(negedge clk); trig1 = 1; @(negedge clk); trig1 = 0;
    repeat (20) @(negedge clk);
    trig1 = 1; trig2 = 1; @(negedge clk); trig1 = 0; trig2 = 0;
    chk(flags[2] && flags[5], "R11 overrun flags", flags, 36);
    chk(q2_status == 0, "R11 q2 trigger ignored", q2_status, 0);
    for (int g = 0; g < 2000 && q1_status == 2'b01; g++) @(negedge clk);
    chk(conv_cnt - c0 == 64, "R11 q1 run unaffected", conv_cnt - c0, 64);
    do_reset(); c0 = conv_cnt;
    @(negedge clk); trig1 = 1; trig2 = 1; @(negedge clk); trig1 = 0; trig2 = 0;
    chk(q1_status == 2'b01 && flags == 6'b100000, "R11 same-cycle q1 wins", flags, 32);
    for (int g = 0; g < 2000 && q1_status == 2'b01; g++) @(negedge clk);
  endtask

  task automatic t_irq_clr();
    int i0;
    do_reset(); q2_begin = 3; irq_en = 0; i0 = irq_cnt[0];
    run(0); repeat (2) @(negedge clk);
    chk(irq_cnt[0] == i0 && flags[0], "R12 disabled strobe silent", irq_cnt[0] - i0, 0);
    @(negedge clk); trig2 = 1; @(negedge clk); trig2 = 0;
    for (int g = 0; g < 2000 && q2_status == 2'b01; g++) @(negedge clk);
    clr(6'b000001);
    chk(flags == 6'b001000, "R12 write-one clears one bit", flags, 8);
  endtask

  initial begin
    t_reset();
    t_q1_bound();
    t_q2_last();
    t_eoq();
    t_pause();
    t_pause_eoq_same();
    t_multi_end();
    t_q2_beyond();
    t_modes();
    t_overrun();
    t_irq_clr();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule